// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block detects interrupts for one GPIO port of `WIDTH` pins (eight by default). Each pin passes through a two-flop synchroniser. A per-pin debounce filter can be switched on for any pin. The block then checks the pin against its own trigger mode. Two configuration bits choose that mode: the type bit selects level or edge, and the polarity bit selects high/rising or low/falling.

Detection results are held in a raw status vector. The enable mask does not affect this vector. The masked status is the raw status ANDed with the enable mask, and the single interrupt output is the OR of the masked bits. In level mode a status bit follows the qualified pin. In edge mode a status bit latches and is released only by an end-of-interrupt write. Software reaches every register through a small word-addressed register port. A write completes in one cycle. A read returns its data, flagged by `rvalid_o`, one cycle after the request.

Register map (word addresses): 0 type (1 = edge), 1 polarity (1 = high/rising), 2 debounce enable, 3 interrupt enable, 4 end-of-interrupt (write-only, reads 0), 5 raw status (read-only), 6 masked status (read-only). Any other address reads 0.

Top module: `gpio_irq_unit`

## Requirements
- R1: With type=0 and polarity=1, raw status bit i equals the synchronised pin i.
- R2: With type=0 and polarity=0, raw status bit i equals the inverse of the synchronised pin i.
- R3: With type=1 and polarity=1, a 0-to-1 transition sets raw bit i, and the bit stays set after the pin returns low.
- R4: With type=1 and polarity=0, a 1-to-0 transition sets raw bit i, and the bit stays set afterwards.
- R5: Writing 1 to bit i of address 4 clears a latched edge bit i. Bits written 0 are unaffected.
- R6: An address-4 write has no effect on bits in level mode (type=0).
- R7: The raw status (address 5) does not depend on the enable register. The masked status (address 6) equals raw AND enable.
- R8: `irq_o` is 1 exactly when some masked status bit is 1.
- R9: With debounce enabled (address 2 bit i = 1), a pin level is accepted only after it holds for DB_SAMPLES consecutive debounce samples, taken every DB_DIV clocks. A shorter pulse leaves the status unchanged.
- R10: If an edge and an end-of-interrupt write for the same bit land in the same cycle, the bit stays set.
- R11: A write that changes bit i of the type or polarity register clears latched status bit i.
- R12: Read data bits above WIDTH are 0. Address 4 and unmapped addresses read 0. After reset, type=0, polarity=all ones, enable=0, raw=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | WIDTH | Asynchronous port pins |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | DATA_W | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | DATA_W | Read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with WIDTH=8, DATA_W=32, DB_DIV=2 and DB_SAMPLES=4. The short sample divider lets a debounce acceptance happen within a few dozen cycles. A three-cycle glitch can then be shown to fall below the four-sample threshold while a steady level passes. Because the pin-to-status latency is fixed at three clocks, the bench can line up an edge and an end-of-interrupt write in the same cycle. With the port at eight pins, all four modes can run at once on separate nibbles and bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TYPE = 3'd0,
    A_POL  = 3'd1,
    A_DBEN = 3'd2,
    A_EN   = 3'd3,
    A_EOI  = 3'd4,
    A_RAW  = 3'd5,
    A_MASK = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= '0;
        else         ff_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int WIDTH      = 8,
  parameter int DB_DIV     = 16,
  parameter int DB_SAMPLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  localparam int DIV_W = (DB_DIV > 1) ? $clog2(DB_DIV) : 1;
  localparam int CNT_W = $clog2(DB_SAMPLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DB_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DB_SAMPLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_SAMPLES - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  logic [WIDTH-1:0]            cand_q, stable_q;
  logic [WIDTH-1:0][CNT_W-1:0] cnt_q;

  // cnt_q counts consecutive equal samples of cand_q; saturates at DB_SAMPLES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= '0;
      stable_q <= '0;
      for (int i = 0; i < WIDTH; i++) cnt_q[i] <= CNT_FULL;
    end else if (tick) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (pin_i[i] != cand_q[i]) begin
          cand_q[i] <= pin_i[i];
          cnt_q[i]  <= CNT_W'(1);
        end else if (cnt_q[i] != CNT_FULL) begin
          cnt_q[i] <= cnt_q[i] + 1'b1;
          if (cnt_q[i] == CNT_LAST) stable_q[i] <= cand_q[i];
        end
      end
    end
  end

  assign pin_o = stable_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    a_r9_hold_between_ticks: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      !tick |=> $stable(stable_q[i]));
    a_r9_accept_only_settled: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (tick && cnt_q[i] != CNT_LAST) |=> $stable(stable_q[i]));
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] eoi_i,
  input  logic [WIDTH-1:0] cfg_clr_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] prev_q, raw_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;

  assign hit = (pol_i & sig_i & ~prev_q) | (~pol_i & ~sig_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else begin
      for (int i = 0; i < WIDTH; i++) begin
        if (cfg_clr_i[i])         raw_q[i] <= 1'b0;
        else if (!edge_mode_i[i]) raw_q[i] <= ~(sig_i[i] ^ pol_i[i]);
        else if (hit[i])          raw_q[i] <= 1'b1;
        else if (eoi_i[i])        raw_q[i] <= 1'b0;
      end
    end
  end

  assign raw_o = raw_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    a_r3_edge_sticky: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[i] && raw_q[i] && !eoi_i[i] && !cfg_clr_i[i]) |=> raw_q[i]);
    a_r5_eoi_clears: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[i] && eoi_i[i] && !hit[i] && !cfg_clr_i[i]) |=> !raw_q[i]);
    a_r10_edge_wins: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[i] && hit[i] && !cfg_clr_i[i]) |=> raw_q[i]);
    a_r11_cfg_clear: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      cfg_clr_i[i] |=> !raw_q[i]);
    a_r6_level_tracks: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (!edge_mode_i[i] && !cfg_clr_i[i] && (sig_i[i] != pol_i[i])) |=> !raw_q[i]);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DATA_W     = 32,
  parameter int DB_DIV     = 16,
  parameter int DB_SAMPLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - WIDTH;

  logic [WIDTH-1:0] type_q, pol_q, dben_q, en_q;
  logic [WIDTH-1:0] pin_sync, pin_db, pin_sel, raw, masked;
  logic [WIDTH-1:0] wd, eoi, cfg_clr;
  logic             wr;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(addr_i);
  assign wd   = wdata_i[WIDTH-1:0];
  assign wr   = req_i & we_i;

  wire unused_wdata = ^wdata_i[DATA_W-1:WIDTH];

  gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync));

  gpio_irq_debounce #(.WIDTH(WIDTH), .DB_DIV(DB_DIV), .DB_SAMPLES(DB_SAMPLES)) u_db (
    .clk_i, .rst_ni, .pin_i(pin_sync), .pin_o(pin_db));

  assign pin_sel = (dben_q & pin_db) | (~dben_q & pin_sync);

  // config writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      pol_q  <= '1;
      dben_q <= '0;
      en_q   <= '0;
    end else if (wr) begin
      case (addr)
        A_TYPE:  type_q <= wd;
        A_POL:   pol_q  <= wd;
        A_DBEN:  dben_q <= wd;
        A_EN:    en_q   <= wd;
        default: ;
      endcase
    end
  end

  assign eoi     = (wr && addr == A_EOI) ? wd : '0;
  assign cfg_clr = (wr && addr == A_TYPE) ? (wd ^ type_q) :
                   (wr && addr == A_POL)  ? (wd ^ pol_q)  : '0;

  gpio_irq_detect #(.WIDTH(WIDTH)) u_det (
    .clk_i, .rst_ni,
    .sig_i(pin_sel), .edge_mode_i(type_q), .pol_i(pol_q),
    .eoi_i(eoi), .cfg_clr_i(cfg_clr), .raw_o(raw));

  assign masked = raw & en_q;
  assign irq_o  = |masked;

  // read path
  logic [WIDTH-1:0] rsel;
  always_comb begin
    case (addr)
      A_TYPE:  rsel = type_q;
      A_POL:   rsel = pol_q;
      A_DBEN:  rsel = dben_q;
      A_EN:    rsel = en_q;
      A_RAW:   rsel = raw;
      A_MASK:  rsel = masked;
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i && !we_i) rdata_o <= {{PAD_W{1'b0}}, rsel};
    end
  end

  a_r12_pad_zero: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[DATA_W-1:WIDTH] == '0));
  a_r7_mask_subset: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr) == A_MASK) |-> ((rdata_o[WIDTH-1:0] & ~$past(en_q)) == '0));
  a_r8_irq_needs_enable: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
  localparam int W  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  pin = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rvalid, irq;
  logic [DW-1:0] rdata;

  always #5 clk = ~clk;

  gpio_irq_unit #(.WIDTH(W), .DATA_W(DW), .DB_DIV(2), .DB_SAMPLES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq));

  typedef struct {
    logic [DW-1:0] exp;
    logic          chk_irq;
    logic          exp_irq;
    string         tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected read data: got %h expected none", rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
        end
        if (it.chk_irq) begin
          n_chk++;
          if (irq !== it.exp_irq) begin
            n_fail++;
            $display("FAIL %s irq: got %b expected %b", it.tag, irq, it.exp_irq);
          end
        end
      end
    end
  end

  // all tasks start and end at a negedge
  task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] e, input string tag,
                        input logic ci = 1'b0, input logic ei = 1'b0);
    item_t it;
    it.exp = DW'(e); it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
    q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd_chk(3'd0, 8'h00, "R12 reset type");
    rd_chk(3'd1, 8'hFF, "R12 reset pol");
    rd_chk(3'd5, 8'h00, "R12 reset raw", 1'b1, 1'b0);
    // R1 active-high level
    pin = 8'h05; settle();
    rd_chk(3'd5, 8'h05, "R1 level high");
    pin = 8'h00; settle();
    rd_chk(3'd5, 8'h00, "R1 level release");
    // R2 active-low level on bits 0-3
    wr_reg(3'd1, 8'hF0); settle();
    rd_chk(3'd5, 8'h0F, "R2 level low");
    pin = 8'h03; settle();
    rd_chk(3'd5, 8'h0C, "R2 level low partial");
    // R3 rising edge on bits 4,5
    wr_reg(3'd0, 8'h30); settle();
    pin = 8'h13; settle();
    rd_chk(3'd5, 8'h1C, "R3 rising latch");
    pin = 8'h03; settle();
    rd_chk(3'd5, 8'h1C, "R3 sticky after return");
    // R7 / R8 enable and mask
    wr_reg(3'd3, 8'h10);
    rd_chk(3'd6, 8'h10, "R7 masked", 1'b1, 1'b1);
    rd_chk(3'd5, 8'h1C, "R7 raw with enable");
    wr_reg(3'd3, 8'h00);
    rd_chk(3'd6, 8'h00, "R8 masked off", 1'b1, 1'b0);
    rd_chk(3'd5, 8'h1C, "R7 raw unchanged when disabled");
    // R5 end of interrupt
    wr_reg(3'd4, 8'h20); settle(2);
    rd_chk(3'd5, 8'h1C, "R5 eoi zero bits ignored");
    wr_reg(3'd4, 8'h10); settle(2);
    rd_chk(3'd5, 8'h0C, "R5 eoi clears edge");
    // R6 eoi ignored by level bits
    wr_reg(3'd4, 8'h0F); settle(2);
    rd_chk(3'd5, 8'h0C, "R6 eoi on level bits");
    // R4 falling edge on bits 6,7
    wr_reg(3'd0, 8'hF0);
    wr_reg(3'd1, 8'h30); settle();
    pin = 8'h43; settle();
    rd_chk(3'd5, 8'h0C, "R4 no latch on rise");
    pin = 8'h03; settle();
    rd_chk(3'd5, 8'h4C, "R4 falling latch");
    // R11 polarity change clears latched bit
    wr_reg(3'd1, 8'h70); settle(2);
    rd_chk(3'd5, 8'h0C, "R11 cfg change clears");
    // R10 edge and eoi in same cycle
    pin = 8'h13; settle();
    rd_chk(3'd5, 8'h1C, "R10 setup latch");
    pin = 8'h03; settle();
    pin = 8'h13;
    settle(2);
    wr_reg(3'd4, 8'h10); settle(2);
    rd_chk(3'd5, 8'h1C, "R10 edge wins over eoi");
    // R9 debounce on bit 7 (rising)
    wr_reg(3'd1, 8'hF0);
    wr_reg(3'd2, 8'h80); settle(8);
    pin = 8'h93; settle(3);
    pin = 8'h13; settle(24);
    rd_chk(3'd5, 8'h1C, "R9 glitch filtered");
    pin = 8'h93; settle(30);
    rd_chk(3'd5, 8'h9C, "R9 stable level accepted");
    wr_reg(3'd3, 8'h84);
    rd_chk(3'd6, 8'h84, "R8 masked combined", 1'b1, 1'b1);
    // R12 unmapped and eoi read as zero
    rd_chk(3'd4, 8'h00, "R12 eoi reads zero");
    rd_chk(3'd7, 8'h00, "R12 unmapped reads zero");
    settle(4);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 pending reads: got %0d expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule